// File: doc/BRIEF.md
# Memory-Mapped Eight-Pin Bidirectional Port

This block is a general-purpose byte-wide pin port that hangs off a simple processor memory bus. The processor controls it with plain load and store cycles. It writes a direction byte that makes each pin a driver or a receiver, and it writes an output byte that sets the level driven on the pins that act as drivers. To sense the pins, it loads from a third address, which returns the live level of every pin.

The bus carries a 32-bit address, a master-enable strobe, a read/not-write line, a 2-bit access-width code and 32-bit data. The port decodes all 32 address bits against a base address set by a parameter. Only the low data byte is meaningful. The pad side is modelled without real tri-states. The block drives an output-enable and an output value for each pin. For each pin it receives whether an external source drives it and at which level. An undriven receiving pin resolves to 1, as if held high by a pull-up.

Top module: `gpio_byte_port`

## Requirements
- R1: While reset is active and after its release, the direction and output registers are 0, so `pin_oe` and `pin_out` are 0x00, and `bus_rdata` is zero with `bus_rvalid` low.
- R2: `pin_oe[i]` equals direction bit i (1 = pin drives, 0 = pin receives), and `pin_out[i]` equals output bit i, for all eight pins independently.
- R3: A cycle with `bus_en`=1, `bus_rnw`=0 and `bus_addr` equal to BASE_ADDR+0 loads `bus_wdata[7:0]` into the output register. The new value shows on `pin_out` after that clock edge.
- R4: A cycle with `bus_en`=1, `bus_rnw`=0 and `bus_addr` equal to BASE_ADDR+2 loads `bus_wdata[7:0]` into the direction register. The new value shows on `pin_oe` after that clock edge.
- R5: A cycle with `bus_en`=1, `bus_rnw`=1 and `bus_addr` equal to BASE_ADDR+4 returns the pin levels in `bus_rdata[7:0]` after the next clock edge, with bits 31:8 zero and `bus_rvalid`=1. The level of a driving pin is its output bit. The level of a receiving pin with `pad_drive`=1 is its `pad_value`. The level of a receiving pin with `pad_drive`=0 is 1.
- R6: When `bus_en` is 0, no register changes and no read data is returned, whatever the other bus inputs are.
- R7: An access whose address differs from all three port addresses in any bit has no effect on either register and returns zero with `bus_rvalid` low.
- R8: Only the input address is readable. A read of BASE_ADDR+0 or BASE_ADDR+2 returns zero with `bus_rvalid` low and changes no register. A write to BASE_ADDR+4 changes no register.
- R9: The width code (00 byte, 01 word, 11 long-word, 10 unused) does not alter any access. Every decoded write updates only the byte from `bus_wdata[7:0]`.
- R10: In any cycle after which no input read was decoded, `bus_rdata` is all zero and `bus_rvalid` is low, so the read bus can be OR-combined with other slaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Master enable; the transaction is ignored when 0 |
| bus_rnw | input | 1 | 1 = load, 0 = store |
| bus_size | input | 2 | Access width code (00 byte, 01 word, 11 long-word, 10 unused) |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Store data; the port uses bits 7:0 |
| bus_rdata | output | 32 | Load data, registered; zero when no input read was decoded |
| bus_rvalid | output | 1 | High in the cycle after a decoded input read |
| pad_drive | input | 8 | Per pin: an external source drives the pin |
| pad_value | input | 8 | Per pin: level of the external source |
| pin_oe | output | 8 | Per pin output enable (direction register) |
| pin_out | output | 8 | Per pin driven level (output register) |

## Verification
On every cycle, the assertions check the following at the ports. A decoded store lands in `pin_out` or `pin_oe` on the next edge. With master enable low, both registers hold. Any cycle without a decoded input read leaves zero read data. Returned data on driving pins echoes the output register. The decoder never selects two registers at once. The bench scenarios alone show several behaviours: the pull-up value on undriven receiving pins, the pass-through of external levels on receiving pins, the reset state, and the way an address with a single flipped bit, a read of a write-only address and a write to the read-only address leave the whole port unchanged.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Access width code carried on the bus; the port treats all alike.
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_RSVD = 2'b10,
    SZ_LONG = 2'b11
  } bus_size_e;

  // Byte offsets from the port base address.
  localparam int unsigned OFS_OUT = 0;
  localparam int unsigned OFS_DIR = 2;
  localparam int unsigned OFS_IN  = 4;

  // One-hot-or-none selection produced by the address decoder.
  typedef struct packed {
    logic wr_out;
    logic wr_dir;
    logic rd_in;
  } port_sel_t;

endpackage

// File: rtl/gpio_port_rst_sync.sv
module gpio_port_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_qn
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_qn = sync_q[STAGES-1];

endmodule

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0031_0000
) (
  input  logic              clk,
  input  logic              rst_qn,
  input  logic              bus_en,
  input  logic              bus_rnw,
  input  logic [ADDR_W-1:0] bus_addr,
  output port_sel_t         sel
);

  localparam logic [ADDR_W-1:0] ADDR_OUT = BASE_ADDR + ADDR_W'(OFS_OUT);
  localparam logic [ADDR_W-1:0] ADDR_DIR = BASE_ADDR + ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] ADDR_IN  = BASE_ADDR + ADDR_W'(OFS_IN);

  logic hit_out;
  logic hit_dir;
  logic hit_in;

  // Full compare of every address bit, then qualify with strobe and direction.
  always_comb begin
    hit_out    = (bus_addr == ADDR_OUT);
    hit_dir    = (bus_addr == ADDR_DIR);
    hit_in     = (bus_addr == ADDR_IN);
    sel.wr_out = bus_en && !bus_rnw && hit_out;
    sel.wr_dir = bus_en && !bus_rnw && hit_dir;
    sel.rd_in  = bus_en &&  bus_rnw && hit_in;
  end

  a_r7_sel_onehot: assert property (@(posedge clk) disable iff (!rst_qn)
    $onehot0({sel.wr_out, sel.wr_dir, sel.rd_in}));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_qn,
  input  port_sel_t       sel,
  input  logic [PINS-1:0] wbyte,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] out_q
);

  logic [PINS-1:0] dir_d;
  logic [PINS-1:0] out_d;

  // Next-state with explicit enables.
  always_comb begin
    dir_d = dir_q;
    out_d = out_q;
    if (sel.wr_dir) dir_d = wbyte;
    if (sel.wr_out) out_d = wbyte;
  end

  always_ff @(posedge clk or negedge rst_qn) begin
    if (!rst_qn) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      dir_q <= dir_d;
      out_q <= out_d;
    end
  end

  // R8: registers move only on their own decoded store.
  a_r8_dir_hold: assert property (@(posedge clk) disable iff (!rst_qn)
    !sel.wr_dir |=> $stable(dir_q));
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_qn)
    !sel.wr_out |=> $stable(out_q));

endmodule

// File: rtl/gpio_port_pins.sv
module gpio_port_pins #(
  parameter int unsigned PINS = 8
) (
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] out_q,
  input  logic [PINS-1:0] pad_drive,
  input  logic [PINS-1:0] pad_value,
  output logic [PINS-1:0] pin_oe,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_level
);

  // One slice per pin: own driver wins, else external source, else pull-up.
  generate
    for (genvar g = 0; g < PINS; g++) begin : g_slice
      assign pin_oe[g]    = dir_q[g];
      assign pin_out[g]   = out_q[g];
      assign pin_level[g] = dir_q[g]     ? out_q[g]     :
                            pad_drive[g] ? pad_value[g] : 1'b1;
    end
  endgenerate

endmodule

// File: rtl/gpio_port_rdstage.sv
module gpio_port_rdstage #(
  parameter int unsigned PINS   = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_qn,
  input  logic              rd_in,
  input  logic [PINS-1:0]   pin_level,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [PINS-1:0] lvl_q;
  logic [PINS-1:0] lvl_d;
  logic            vld_q;
  logic            vld_d;

  always_comb begin
    vld_d = rd_in;
    lvl_d = rd_in ? pin_level : '0;
  end

  always_ff @(posedge clk or negedge rst_qn) begin
    if (!rst_qn) begin
      lvl_q <= '0;
      vld_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      vld_q <= vld_d;
    end
  end

  assign rdata  = {{(DATA_W-PINS){1'b0}}, lvl_q};
  assign rvalid = vld_q;

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_qn)
    rd_in |=> rvalid && (rdata[PINS-1:0] == $past(pin_level)));

endmodule

// File: rtl/gpio_byte_port.sv
module gpio_byte_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       PINS      = 8,
  parameter int unsigned       SYNC_STG  = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0031_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_rnw,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [PINS-1:0]   pad_drive,
  input  logic [PINS-1:0]   pad_value,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_out
);

  localparam logic [ADDR_W-1:0] ADDR_OUT = BASE_ADDR + ADDR_W'(OFS_OUT);
  localparam logic [ADDR_W-1:0] ADDR_DIR = BASE_ADDR + ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] ADDR_IN  = BASE_ADDR + ADDR_W'(OFS_IN);

  logic            rst_qn;
  port_sel_t       sel;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] out_q;
  logic [PINS-1:0] pin_level;
  logic            unused_bits;

  // Width code and upper data lanes carry no meaning for a byte port (R9).
  assign unused_bits = ^{bus_size, bus_wdata[DATA_W-1:PINS]};

  gpio_port_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_qn (rst_qn)
  );

  gpio_port_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .clk      (clk),
    .rst_qn   (rst_qn),
    .bus_en   (bus_en),
    .bus_rnw  (bus_rnw),
    .bus_addr (bus_addr),
    .sel      (sel)
  );

  gpio_port_regs #(.PINS(PINS)) u_regs (
    .clk    (clk),
    .rst_qn (rst_qn),
    .sel    (sel),
    .wbyte  (bus_wdata[PINS-1:0]),
    .dir_q  (dir_q),
    .out_q  (out_q)
  );

  gpio_port_pins #(.PINS(PINS)) u_pins (
    .dir_q     (dir_q),
    .out_q     (out_q),
    .pad_drive (pad_drive),
    .pad_value (pad_value),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .pin_level (pin_level)
  );

  gpio_port_rdstage #(.PINS(PINS), .DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_qn    (rst_qn),
    .rd_in     (sel.rd_in),
    .pin_level (pin_level),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid)
  );

  // Port-level properties.
  a_r3_out_store: assert property (@(posedge clk) disable iff (!rst_qn)
    (bus_en && !bus_rnw && bus_addr == ADDR_OUT)
      |=> pin_out == $past(bus_wdata[PINS-1:0]));

  a_r4_dir_store: assert property (@(posedge clk) disable iff (!rst_qn)
    (bus_en && !bus_rnw && bus_addr == ADDR_DIR)
      |=> pin_oe == $past(bus_wdata[PINS-1:0]));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_qn)
    !bus_en |=> $stable(pin_oe) && $stable(pin_out));

  a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rst_qn)
    !(bus_en && bus_rnw && bus_addr == ADDR_IN)
      |=> (bus_rdata == '0) && !bus_rvalid);

  a_r5_echo_driven: assert property (@(posedge clk) disable iff (!rst_qn)
    bus_rvalid |-> ((bus_rdata[PINS-1:0] ^ $past(pin_out)) & $past(pin_oe)) == '0);

endmodule

// File: tb/gpio_byte_port_tb.sv
module gpio_byte_port_tb_top;
  import gpio_port_pkg::*;

  localparam logic [31:0] BASE = 32'h0031_0000;
  localparam logic [31:0] A_OUT = BASE + 32'd0;
  localparam logic [31:0] A_DIR = BASE + 32'd2;
  localparam logic [31:0] A_IN  = BASE + 32'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_rnw = 1'b0;
  logic [1:0]  bus_size = 2'b00;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  pad_drive = '0;
  logic [7:0]  pad_value = '0;
  logic [7:0]  pin_oe;
  logic [7:0]  pin_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [7:0] m_dir = '0;
  logic [7:0] m_out = '0;

  always #10 clk = ~clk; // 50 MHz

  gpio_byte_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rnw(bus_rnw),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pad_drive(pad_drive), .pad_value(pad_value),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  function automatic logic [7:0] exp_level(logic [7:0] dir, logic [7:0] dout,
                                           logic [7:0] drv, logic [7:0] val);
    return (dir & dout) | (~dir & ((drv & val) | ~drv));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, commit at the rising edge, check at the next falling edge.
  task automatic txn(string tag, logic en, logic rnw, logic [1:0] sz,
                     logic [31:0] addr, logic [31:0] wd,
                     logic [7:0] drv, logic [7:0] val);
    logic        rd_hit;
    logic [31:0] exp_rd;
    bus_en = en; bus_rnw = rnw; bus_size = sz; bus_addr = addr;
    bus_wdata = wd; pad_drive = drv; pad_value = val;
    rd_hit = en && rnw && (addr == A_IN);
    exp_rd = rd_hit ? {24'h0, exp_level(m_dir, m_out, drv, val)} : 32'h0;
    @(posedge clk);
    if (en && !rnw && addr == A_OUT) m_out = wd[7:0];
    if (en && !rnw && addr == A_DIR) m_dir = wd[7:0];
    @(negedge clk);
    chk({tag, " R2/R4 pin_oe"},  {24'h0, pin_oe},  {24'h0, m_dir});
    chk({tag, " R2/R3 pin_out"}, {24'h0, pin_out}, {24'h0, m_out});
    chk({tag, " R5/R10 rdata"},  bus_rdata, exp_rd);
    chk({tag, " R5/R10 rvalid"}, {31'h0, bus_rvalid}, {31'h0, rd_hit});
    bus_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 oe in reset",  {24'h0, pin_oe},  32'h0);
    chk("R1 out in reset", {24'h0, pin_out}, 32'h0);
    chk("R1 rvalid in reset", {31'h0, bus_rvalid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 oe after reset",  {24'h0, pin_oe},  32'h0);
    chk("R1 rdata after reset", bus_rdata, 32'h0);

    // R5: all inputs, nothing driving -> pull-up gives all ones
    txn("R5 pullup", 1, 1, SZ_BYTE, A_IN, 32'h0, 8'h00, 8'h00);
    // R5: external levels pass through on receiving pins
    txn("R5 external", 1, 1, SZ_BYTE, A_IN, 32'h0, 8'hFF, 8'h3C);
    // R9/R4: word-sized store updates only the low byte
    txn("R9 word dir", 1, 0, SZ_WORD, A_DIR, 32'hABCD_125A, 8'h00, 8'h00);
    // R9/R3: long store on output register
    txn("R9 long out", 1, 0, SZ_LONG, A_OUT, 32'h1234_56F0, 8'h00, 8'h00);
    txn("R9 rsvd out", 1, 0, SZ_RSVD, A_OUT, 32'hFFFF_FF0F, 8'h00, 8'h00);
    // R5: mixed pins, driven pins echo output, partly driven inputs
    txn("R5 mixed", 1, 1, SZ_BYTE, A_IN, 32'h0, 8'h81, 8'h00);
    // R6: strobe low blocks a store
    txn("R6 no enable", 0, 0, SZ_BYTE, A_OUT, 32'h0000_00AA, 8'h00, 8'h00);
    txn("R6 no enable read", 0, 1, SZ_BYTE, A_IN, 32'h0, 8'h00, 8'h00);
    // R7: one flipped address bit
    txn("R7 addr bit31", 1, 0, SZ_BYTE, A_DIR ^ 32'h8000_0000, 32'h0000_0011, 8'h00, 8'h00);
    txn("R7 addr bit0",  1, 0, SZ_BYTE, A_OUT ^ 32'h1, 32'h0000_0022, 8'h00, 8'h00);
    txn("R7 read miss",  1, 1, SZ_BYTE, A_IN ^ 32'h10, 32'h0, 8'h00, 8'h00);
    // R8: write-only and read-only addresses
    txn("R8 read dir",  1, 1, SZ_BYTE, A_DIR, 32'h0, 8'h00, 8'h00);
    txn("R8 read out",  1, 1, SZ_BYTE, A_OUT, 32'h0, 8'h00, 8'h00);
    txn("R8 write in",  1, 0, SZ_BYTE, A_IN, 32'h0000_0077, 8'h00, 8'h00);

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      case ($urandom % 7)
        0: a = A_OUT;
        1: a = A_DIR;
        2, 3: a = A_IN;
        4: a = BASE ^ (32'h1 << ($urandom % 32));
        5: a = BASE + 32'd1;
        default: a = $urandom;
      endcase
      txn("RND", ($urandom % 8) != 0, $urandom % 2, 2'($urandom),
          a, $urandom, 8'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule